// File: doc/BRIEF.md
# USB Host Controller Operational Register Bank

This block holds the operational registers of a USB host controller of the open host controller kind. Software reaches it through a simple bus that moves one 32-bit word per request. A request is sampled on a rising clock edge. A read returns its data on the next cycle, and a write updates the selected register on the edge that samples it. Each register follows its own write rule:

- plain store;
- OR-in of written ones;
- write-one-to-clear;
- a set/clear pair of addresses that act on one enable mask;
- low-bit masking on the pointer registers;
- an alignment-query handshake on the communications-area pointer.

The rest of the controller reports interrupt-worthy events on an event input. The bank latches these events into the interrupt status register and combines them with the enable mask to drive one interrupt line. When software sets the reset bit in command status, the whole bank goes back to its initial values on the following edge. The only exception is bit 8 of control, which keeps its value.

Top module: `usbhc_opregs`

## Requirements
- R1: After the reset input is released, every register reads as follows, and irq is 0. Control, command status, interrupt status, interrupt enable, the communications-area pointer, both list head pointers and periodic start read 0. Frame interval reads 0x27782EDF.
- R2: A read request gives rsp_valid=1 with its data in the following cycle. A write request gives rsp_valid=0 in the following cycle.
- R3: An access whose byte address has bit 1 or bit 0 set is treated as follows. A read returns 0xFFFFFFFF. A write changes nothing, and this includes not arming the alignment query.
- R4: Reads of words 7, 9, 11, 12, 14 and 15, and of any word at 18 or above, return 0xFFFFFFFF. Writes to those words have no effect.
- R5: Word 0 always reads 0x00000010, and writes to it are ignored.
- R6: Command status (word 2) handles writes as follows. Bits 7:6 always read 0. Written ones in the other positions are ORed in. Written zeros leave bits unchanged.
- R7: A write that sets bit 0 of command status resets the bank on the next edge. Control keeps only its bit 8. Every other register takes its R1 value. A write sampled on that next edge is lost.
- R8: Interrupt status (word 3) is set by hc_event, but only in bits 6:0 and 30. Writing a one to a bit clears it. If an event and a clear hit the same bit in the same cycle, the event wins.
- R9: Writing word 4 ORs the data into the enable mask. Writing word 5 clears the written bits from the mask. Reading word 4 returns the mask, and reading word 5 returns its inverse.
- R10: Writing 0xFFFFFFFF to word 6 leaves the stored pointer unchanged and arms a query. The next aligned read of word 6 returns 0x000000FF and disarms the query. Any other write to word 6 stores the value with bits 7:0 cleared.
- R11: Words 8 and 10 store the written value with bits 2:0 cleared.
- R12: Word 17 always reads 0x00000628, and writes to it are ignored.
- R13: irq is 1 exactly when enable bit 31 is set and some bit in positions 6:0 or 30 is set in both interrupt status and the enable mask.
- R14: Control (word 1), frame interval (word 13) and periodic start (word 16) read back the full 32-bit value last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address inside the bank |
| req_wdata | input | 32 | Write data |
| hc_event | input | 32 | Interrupt events from the controller core, one-cycle pulses |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| irq | output | 1 | Interrupt request |

## Verification
Two pairs of actions can land on the same clock edge.

- **Event versus clear.** A hardware event and a software write-one-to-clear can target the same interrupt status bit. The bench drives an event pulse on bit 1 in the cycle that carries the clearing write. It then expects the bit to read back as set and irq to stay high.
- **Reset versus write.** A pending soft reset can meet an ordinary write. The bench issues a frame-interval write in the cycle right after the reset command. It then expects frame interval to read its reset value and control to hold only bit 8.

// File: rtl/usbhc_pkg.sv
package usbhc_pkg;

    localparam int unsigned NREG = 18;

    localparam int unsigned W_REV   = 0;
    localparam int unsigned W_CTL   = 1;
    localparam int unsigned W_CMD   = 2;
    localparam int unsigned W_ISTS  = 3;
    localparam int unsigned W_IEN   = 4;
    localparam int unsigned W_IDIS  = 5;
    localparam int unsigned W_HCCA  = 6;
    localparam int unsigned W_CHEAD = 8;
    localparam int unsigned W_BHEAD = 10;
    localparam int unsigned W_FMI   = 13;
    localparam int unsigned W_PST   = 16;
    localparam int unsigned W_LST   = 17;

    // words that answer the bus; the others read all ones
    localparam logic [NREG-1:0] IMPL_MASK = 18'h3257F;

    localparam logic [31:0] REV_VAL    = 32'h0000_0010;
    localparam logic [31:0] LST_VAL    = 32'h0000_0628;
    localparam logic [31:0] SRC_MASK   = 32'h4000_007F;
    localparam logic [31:0] CMD_RO     = 32'h0000_00C0;
    localparam logic [31:0] CTL_KEEP   = 32'h0000_0100;
    localparam logic [31:0] HCCA_LOW   = 32'h0000_00FF;
    localparam logic [31:0] HEAD_LOW   = 32'h0000_0007;
    localparam logic [31:0] ALL_ONES   = 32'hFFFF_FFFF;

    typedef struct packed {
        logic [31:0] ctl;
        logic [31:0] cmd;
        logic [31:0] ists;
        logic [31:0] ien;
        logic [31:0] hcca;
        logic        hq;
        logic [31:0] chead;
        logic [31:0] bhead;
        logic [31:0] fmi;
        logic [31:0] pst;
    } regs_t;

    typedef struct packed {
        regs_t       r;
        logic        rsp_v;
        logic [31:0] rdata;
    } st_t;

    function automatic regs_t regs_init(input logic [31:0] ctl_kept,
                                        input logic [31:0] fmi_init);
        regs_t v;
        v       = '0;
        v.ctl   = ctl_kept & CTL_KEEP;
        v.fmi   = fmi_init;
        return v;
    endfunction

endpackage

// File: rtl/usbhc_decode.sv
module usbhc_decode
    import usbhc_pkg::*;
#(
    parameter int unsigned ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NREG-1:0]   sel
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic aligned;
    assign aligned = (addr[1:0] == 2'b00);

    for (genvar i = 0; i < NREG; i++) begin : g_sel
        if (IMPL_MASK[i]) begin : g_impl
            assign sel[i] = aligned && (addr[ADDR_W-1:2] == WORD_W'(i));
        end else begin : g_hole
            assign sel[i] = 1'b0;
        end
    end

    // R4: at most one register answers any address
    always_comb begin
        if (!$isunknown(addr)) begin
            p_sel_onehot_r4: assert ($onehot0(sel));
        end
    end

endmodule

// File: rtl/usbhc_irq.sv
module usbhc_irq
    import usbhc_pkg::*;
(
    input  logic [31:0] ists,
    input  logic [31:0] ien,
    output logic        irq
);
    logic [31:0] live;
    assign live = ists & ien & SRC_MASK;
    assign irq  = ien[31] && (|live);
endmodule

// File: rtl/usbhc_opregs.sv
module usbhc_opregs
    import usbhc_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter logic [31:0] FMI_INIT = 32'h2778_2EDF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [31:0]       hc_event,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              irq
);
    st_t             q, d;
    logic [NREG-1:0] sel;
    logic            rd, wr;
    logic [31:0]     rd_val, clr;

    usbhc_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (req_addr),
        .sel  (sel)
    );

    usbhc_irq u_irq (
        .ists (q.r.ists),
        .ien  (q.r.ien),
        .irq  (irq)
    );

    assign rd = req_valid && !req_write;
    assign wr = req_valid &&  req_write;

    always_comb begin
        d       = q;
        d.rsp_v = 1'b0;

        rd_val = ALL_ONES;
        if (sel[W_REV])   rd_val = REV_VAL;
        if (sel[W_CTL])   rd_val = q.r.ctl;
        if (sel[W_CMD])   rd_val = q.r.cmd;
        if (sel[W_ISTS])  rd_val = q.r.ists;
        if (sel[W_IEN])   rd_val = q.r.ien;
        if (sel[W_IDIS])  rd_val = ~q.r.ien;
        if (sel[W_HCCA])  rd_val = q.r.hq ? HCCA_LOW : q.r.hcca;
        if (sel[W_CHEAD]) rd_val = q.r.chead;
        if (sel[W_BHEAD]) rd_val = q.r.bhead;
        if (sel[W_FMI])   rd_val = q.r.fmi;
        if (sel[W_PST])   rd_val = q.r.pst;
        if (sel[W_LST])   rd_val = LST_VAL;

        if (rd) begin
            d.rsp_v = 1'b1;
            d.rdata = rd_val;
            if (sel[W_HCCA]) d.r.hq = 1'b0;
        end

        // hardware set beats software clear
        clr       = (wr && sel[W_ISTS]) ? req_wdata : '0;
        d.r.ists  = (q.r.ists & ~clr) | (hc_event & SRC_MASK);

        if (wr) begin
            if (sel[W_CTL])   d.r.ctl   = req_wdata;
            if (sel[W_CMD])   d.r.cmd   = q.r.cmd | (req_wdata & ~CMD_RO);
            if (sel[W_IEN])   d.r.ien   = q.r.ien | req_wdata;
            if (sel[W_IDIS])  d.r.ien   = q.r.ien & ~req_wdata;
            if (sel[W_HCCA]) begin
                if (req_wdata == ALL_ONES) d.r.hq   = 1'b1;
                else                       d.r.hcca = req_wdata & ~HCCA_LOW;
            end
            if (sel[W_CHEAD]) d.r.chead = req_wdata & ~HEAD_LOW;
            if (sel[W_BHEAD]) d.r.bhead = req_wdata & ~HEAD_LOW;
            if (sel[W_FMI])   d.r.fmi   = req_wdata;
            if (sel[W_PST])   d.r.pst   = req_wdata;
        end

        // soft reset lands one edge after the command write
        if (q.r.cmd[0]) d.r = regs_init(q.r.ctl, FMI_INIT);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.r     <= regs_init('0, FMI_INIT);
            q.rsp_v <= 1'b0;
            q.rdata <= '0;
        end else begin
            q <= d;
        end
    end

    assign rsp_valid = q.rsp_v;
    assign rsp_rdata = q.rdata;

    p_rsp_after_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_valid);

    p_no_rsp_after_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> !rsp_valid);

    p_soft_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
        q.r.cmd[0] |=> (q.r.ien == '0 && q.r.ists == '0 && q.r.cmd == '0
                        && q.r.fmi == FMI_INIT && !q.r.hq));

    p_irq_needs_master_r13: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> q.r.ien[31]);

    p_query_disarm_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel[W_HCCA]) |=> !q.r.hq);

    p_lst_value_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && sel[W_LST]) |=> (rsp_rdata == LST_VAL));

endmodule

// File: tb/tb_usbhc_opregs.sv
module tb_usbhc_opregs;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_write;
    logic [7:0]  req_addr;
    logic [31:0] req_wdata, hc_event;
    logic        rsp_valid, irq;
    logic [31:0] rsp_rdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    usbhc_opregs dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .hc_event(hc_event),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        w;
        logic [7:0]  a;
        logic [31:0] d;
        logic [31:0] e;
        logic [7:0]  tag;
    } vec_t;

    localparam int NV = 40;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'h04, 32'hA5A5_1234, 32'h0,         8'd14}, // R14 control
        '{1'b0, 8'h04, 32'h0,         32'hA5A5_1234, 8'd14},
        '{1'b1, 8'h34, 32'h1234_5678, 32'h0,         8'd14}, // R14 frame interval
        '{1'b0, 8'h34, 32'h0,         32'h1234_5678, 8'd14},
        '{1'b1, 8'h40, 32'hDEAD_BEEF, 32'h0,         8'd14}, // R14 periodic start
        '{1'b0, 8'h40, 32'h0,         32'hDEAD_BEEF, 8'd14},
        '{1'b1, 8'h20, 32'hFFFF_FFFF, 32'h0,         8'd11}, // R11 control head
        '{1'b0, 8'h20, 32'h0,         32'hFFFF_FFF8, 8'd11},
        '{1'b1, 8'h28, 32'h0000_1237, 32'h0,         8'd11}, // R11 bulk head
        '{1'b0, 8'h28, 32'h0,         32'h0000_1230, 8'd11},
        '{1'b1, 8'h18, 32'h1234_5678, 32'h0,         8'd10}, // R10 store
        '{1'b0, 8'h18, 32'h0,         32'h1234_5600, 8'd10},
        '{1'b1, 8'h18, 32'hFFFF_FFFF, 32'h0,         8'd10}, // R10 arm query
        '{1'b0, 8'h18, 32'h0,         32'h0000_00FF, 8'd10},
        '{1'b0, 8'h18, 32'h0,         32'h1234_5600, 8'd10},
        '{1'b1, 8'h00, 32'h0000_0005, 32'h0,         8'd5},  // R5 revision
        '{1'b0, 8'h00, 32'h0,         32'h0000_0010, 8'd5},
        '{1'b1, 8'h44, 32'h0000_0000, 32'h0,         8'd12}, // R12 threshold
        '{1'b0, 8'h44, 32'h0,         32'h0000_0628, 8'd12},
        '{1'b0, 8'h1C, 32'h0,         32'hFFFF_FFFF, 8'd4},  // R4 word 7
        '{1'b1, 8'h30, 32'h0000_0001, 32'h0,         8'd4},  // R4 word 12
        '{1'b0, 8'h30, 32'h0,         32'hFFFF_FFFF, 8'd4},
        '{1'b0, 8'h48, 32'h0,         32'hFFFF_FFFF, 8'd4},  // R4 word 18
        '{1'b1, 8'h10, 32'h8000_0003, 32'h0,         8'd9},  // R9 set
        '{1'b0, 8'h10, 32'h0,         32'h8000_0003, 8'd9},
        '{1'b1, 8'h14, 32'h0000_0001, 32'h0,         8'd9},  // R9 clear
        '{1'b0, 8'h10, 32'h0,         32'h8000_0002, 8'd9},
        '{1'b0, 8'h14, 32'h0,         32'h7FFF_FFFD, 8'd9},
        '{1'b1, 8'h08, 32'h0000_00C4, 32'h0,         8'd6},  // R6 read-only bits
        '{1'b0, 8'h08, 32'h0,         32'h0000_0004, 8'd6},
        '{1'b1, 8'h08, 32'h0000_0002, 32'h0,         8'd6},
        '{1'b0, 8'h08, 32'h0,         32'h0000_0006, 8'd6},
        '{1'b1, 8'h08, 32'h0000_0000, 32'h0,         8'd6},
        '{1'b0, 8'h08, 32'h0,         32'h0000_0006, 8'd6},
        '{1'b0, 8'h05, 32'h0,         32'hFFFF_FFFF, 8'd3},  // R3 unaligned read
        '{1'b1, 8'h06, 32'h0000_0000, 32'h0,         8'd3},  // R3 unaligned write
        '{1'b0, 8'h04, 32'h0,         32'hA5A5_1234, 8'd3},
        '{1'b1, 8'h19, 32'hFFFF_FFFF, 32'h0,         8'd3},  // R3 no query arm
        '{1'b0, 8'h18, 32'h0,         32'h1234_5600, 8'd3},
        '{1'b0, 8'h3C, 32'h0,         32'hFFFF_FFFF, 8'd4}   // R4 word 15
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    // one bus cycle; entered and left at a falling edge
    task automatic op(input logic w, input logic [7:0] a, input logic [31:0] dat,
                      input logic [31:0] ev, output logic [31:0] rdat, output logic rv);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = dat; hc_event = ev;
        @(negedge clk);
        rv = rsp_valid; rdat = rsp_rdata;
        req_valid = 1'b0; req_write = 1'b0; hc_event = '0;
    endtask

    task automatic idle_evt(input logic [31:0] ev);
        hc_event = ev;
        @(negedge clk);
        hc_event = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v; logic rv;
        op(1'b0, a, '0, '0, v, rv);
        check(req, {31'b0, rv}, 32'h1);
        check(req, v, exp);
    endtask

    task automatic wr_do(input logic [7:0] a, input logic [31:0] dat, input logic [31:0] ev);
        logic [31:0] v; logic rv;
        op(1'b1, a, dat, ev, v, rv);
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v; logic rv;
        rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
        req_addr = '0; req_wdata = '0; hc_event = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check("R1 irq", {31'b0, irq}, 32'h0);
        rd_chk("R1 ctl",   8'h04, 32'h0);
        rd_chk("R1 cmd",   8'h08, 32'h0);
        rd_chk("R1 ists",  8'h0C, 32'h0);
        rd_chk("R1 ien",   8'h10, 32'h0);
        rd_chk("R1 hcca",  8'h18, 32'h0);
        rd_chk("R1 chead", 8'h20, 32'h0);
        rd_chk("R1 bhead", 8'h28, 32'h0);
        rd_chk("R1 fmi",   8'h34, 32'h2778_2EDF);
        rd_chk("R1 pst",   8'h40, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            op(VECS[i].w, VECS[i].a, VECS[i].d, '0, v, rv);
            if (VECS[i].w) begin
                check($sformatf("R2 write no response (vec %0d)", i), {31'b0, rv}, 32'h0);
            end else begin
                check($sformatf("R2 read response (vec %0d)", i), {31'b0, rv}, 32'h1);
                check($sformatf("R%0d vec %0d", VECS[i].tag, i), v, VECS[i].e);
            end
        end

        // R8 / R13: mask now 0x80000002
        idle_evt(32'h0000_0004);
        check("R13 irq unmatched", {31'b0, irq}, 32'h0);
        rd_chk("R8 event latched", 8'h0C, 32'h0000_0004);
        wr_do(8'h10, 32'h0000_0004, '0);
        check("R13 irq matched", {31'b0, irq}, 32'h1);
        wr_do(8'h0C, 32'h0000_0004, '0);
        check("R13 irq after clear", {31'b0, irq}, 32'h0);
        rd_chk("R8 w1c", 8'h0C, 32'h0);
        wr_do(8'h0C, 32'h0000_0002, 32'h0000_0002);   // collision
        check("R13 irq after collision", {31'b0, irq}, 32'h1);
        rd_chk("R8 set beats clear", 8'h0C, 32'h0000_0002);
        idle_evt(32'h0000_0100);
        rd_chk("R8 bit8 event ignored", 8'h0C, 32'h0000_0002);
        wr_do(8'h14, 32'h8000_0000, '0);
        check("R13 master off", {31'b0, irq}, 32'h0);

        // R7 soft reset, next write lost
        wr_do(8'h04, 32'h0000_0F00, '0);
        wr_do(8'h08, 32'h0000_0001, '0);
        wr_do(8'h34, 32'h1111_1111, '0);
        rd_chk("R7 ctl keeps bit8", 8'h04, 32'h0000_0100);
        rd_chk("R7 fmi reset, write lost", 8'h34, 32'h2778_2EDF);
        rd_chk("R7 ien", 8'h10, 32'h0);
        rd_chk("R7 ists", 8'h0C, 32'h0);
        rd_chk("R7 cmd", 8'h08, 32'h0);
        rd_chk("R7 hcca", 8'h18, 32'h0);
        rd_chk("R7 chead", 8'h20, 32'h0);
        rd_chk("R7 pst", 8'h40, 32'h0);
        check("R7 irq", {31'b0, irq}, 32'h0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule